// File: doc/BRIEF.md
# Instruction-Space Page Stack Controller

This block tells the instruction decoder which alternate opcode page applies to a compact 16-bit instruction slot. Software selects a page with a page-control command. Each command pushes a 3-bit subpage number together with a 4-bit activation length onto a shallow stack. The decoder sees the subpage on top of the stack and a flag that says an alternate page is in force. When the stack is empty, decoding falls back to the base instruction set.

Every retired instruction that is not itself a page command uses up one unit of the top entry's length. When the length runs out, that entry leaves the stack. A length of all ones never runs out. A taken branch ends all alternate decoding at once. The whole state packs into one control register, so that a caller can save it and restore it around a call. Two more commands are available: one drops exactly one level and one unwinds to the base set.

Top module: `page_stack_ctl`

## Requirements
- R1: After reset, the stack depth is 0, `altActive` is 0, `subpage` is 0, `overflow` is 0 and `csrRdata` reads 0.
- R2: A retired push command (`cmdOp`=1) with `cmdPage`/`cmdLen` places a new top entry and raises the depth by one. From the next cycle, `subpage` shows the pushed page and `altActive` is 1.
- R3: A push at depth 4 leaves the stack unchanged and sets `overflow`. The flag stays set until reset or a CSR write.
- R4: A retired pop command (`cmdOp`=2) removes exactly the top entry. At depth 0 a pop has no effect.
- R5: A retired unwind command (`cmdOp`=3) returns the depth to 0 at any depth.
- R6: A retired non-command instruction (`cmdOp`=0) at a non-zero depth lowers the top length by one. When the top length is 1 or 0, it pops the top entry instead.
- R7: A top entry with length 15 (all ones) keeps its length and stays on the stack across any number of non-command retires.
- R8: A taken branch clears the stack to depth 0. This takes priority over any command or countdown in the same cycle.
- R9: `csrRdata` layout: entry i (0 = bottom) sits at bits [7i+6:7i], with the page in the upper 3 bits and the length in the lower 4. The depth is in bits [30:28] and `overflow` is in bit 31. The depth never exceeds 4.
- R10: A CSR write loads entries and depth from `csrWdata[30:0]` in one cycle, with the same layout as R9. A depth above 4 saturates to 4. The write clears `overflow`. It takes priority over branch, command and countdown in the same cycle.
- R11: A command with `retire` low has no effect. At depth 0, `subpage` is forced to 0 and `altActive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | One instruction retires this cycle |
| cmdOp | input | 2 | Page command of the retiring instruction: 0 none, 1 push, 2 pop, 3 unwind |
| cmdPage | input | 3 | Subpage number for a push |
| cmdLen | input | 4 | Activation length for a push, 15 = permanent |
| branchTaken | input | 1 | A branch was taken |
| csrWe | input | 1 | CSR write strobe |
| csrWdata | input | 31 | CSR write value (entries and depth) |
| csrRdata | output | 32 | CSR read value (entries, depth, overflow) |
| subpage | output | 3 | Active subpage for the decoder |
| altActive | output | 1 | An alternate page is active |
| overflow | output | 1 | Sticky flag: a push was dropped because the stack was full |

## Verification
Three functions can fall in the same cycle: a CSR restore, a branch, and a retiring instruction that is either a page command or a countdown. The bench drives a branch together with a retiring push and expects an empty stack. It then drives a CSR write together with a branch and a non-command retire, and expects the written image to come back unchanged: no countdown applied and no clear. The final case retires a plain instruction in the cycle after a restore. It is judged by reading back the length field, which must drop by exactly one.

// File: rtl/pgstk_pkg.sv
package pgstk_pkg;

  localparam int unsigned PAGE_W = 3;
  localparam int unsigned LEN_W  = 4;
  localparam int unsigned ENT_W  = PAGE_W + LEN_W;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PUSH   = 2'd1,
    OP_POP    = 2'd2,
    OP_UNWIND = 2'd3
  } pageOp_e;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [LEN_W-1:0]  len;
  } pageEntry_t;

  typedef struct packed {
    logic load;
    logic clear;
    logic push;
    logic pop;
    logic dec;
    logic setOvf;
  } stackStrobe_t;

endpackage

// File: rtl/pgstk_ctrl.sv
module pgstk_ctrl
  import pgstk_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned DW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 retire,
  input  logic [1:0]           cmdOp,
  input  logic                 branchTaken,
  input  logic                 csrWe,
  input  logic [DW-1:0]        depth,
  input  logic [LEN_W-1:0]     topLen,
  output stackStrobe_t         strobes
);

  pageOp_e opCode;
  logic    stackFull;
  logic    stackEmpty;
  logic    lenForever;
  logic    lenLast;

  assign opCode     = pageOp_e'(cmdOp);
  assign stackFull  = (depth == DW'(DEPTH));
  assign stackEmpty = (depth == '0);
  assign lenForever = (topLen == {LEN_W{1'b1}});
  assign lenLast    = (topLen <= LEN_W'(1));

  // Priority: CSR restore, then branch, then the retiring instruction.
  always_comb begin
    strobes = '0;
    if (csrWe) begin
      strobes.load = 1'b1;
    end else if (branchTaken) begin
      strobes.clear = 1'b1;
    end else if (retire) begin
      unique case (opCode)
        OP_PUSH: begin
          if (stackFull) strobes.setOvf = 1'b1;
          else           strobes.push   = 1'b1;
        end
        OP_POP: begin
          if (!stackEmpty) strobes.pop = 1'b1;
        end
        OP_UNWIND: begin
          strobes.clear = 1'b1;
        end
        default: begin
          if (!stackEmpty && !lenForever) begin
            if (lenLast) strobes.pop = 1'b1;
            else         strobes.dec = 1'b1;
          end
        end
      endcase
    end
  end

  // R10: at most one state action per cycle
  p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.load, strobes.clear, strobes.push, strobes.pop, strobes.dec}));

  // R11: an idle cycle never alters the stack
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire && !csrWe && !branchTaken) |-> (strobes == '0));

endmodule

// File: rtl/pgstk_datapath.sv
module pgstk_datapath
  import pgstk_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned DW = $clog2(DEPTH + 1),
  localparam int unsigned STATE_W = DEPTH * ENT_W + DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  stackStrobe_t         strobes,
  input  logic [PAGE_W-1:0]    pushPage,
  input  logic [LEN_W-1:0]     pushLen,
  input  logic [STATE_W-1:0]   loadState,
  output logic [DW-1:0]        depth,
  output pageEntry_t           topEntry,
  output logic                 ovf,
  output logic [STATE_W-1:0]   stateImage
);

  pageEntry_t    stackQ [DEPTH];
  logic [DW-1:0] depthQ;
  logic          ovfQ;
  logic [DW-1:0] loadDepthRaw;
  logic [DW-1:0] loadDepthSat;

  assign loadDepthRaw = loadState[STATE_W-1 -: DW];
  assign loadDepthSat = (loadDepthRaw > DW'(DEPTH)) ? DW'(DEPTH) : loadDepthRaw;

  always_comb begin
    topEntry = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (DW'(i + 1) == depthQ) topEntry = stackQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stackQ[i] <= '0;
      depthQ <= '0;
      ovfQ   <= 1'b0;
    end else if (strobes.load) begin
      for (int i = 0; i < DEPTH; i++) stackQ[i] <= loadState[i*ENT_W +: ENT_W];
      depthQ <= loadDepthSat;
      ovfQ   <= 1'b0;
    end else begin
      if (strobes.clear) begin
        for (int i = 0; i < DEPTH; i++) stackQ[i] <= '0;
        depthQ <= '0;
      end else if (strobes.push) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (DW'(i) == depthQ) begin
            stackQ[i].page <= pushPage;
            stackQ[i].len  <= pushLen;
          end
        end
        depthQ <= depthQ + DW'(1);
      end else if (strobes.pop) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (DW'(i + 1) == depthQ) stackQ[i] <= '0;
        end
        depthQ <= depthQ - DW'(1);
      end else if (strobes.dec) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (DW'(i + 1) == depthQ) stackQ[i].len <= stackQ[i].len - LEN_W'(1);
        end
      end
      if (strobes.setOvf) ovfQ <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_image
    assign stateImage[g*ENT_W +: ENT_W] = stackQ[g];
  end
  assign stateImage[STATE_W-1 -: DW] = depthQ;

  assign depth = depthQ;
  assign ovf   = ovfQ;

  // R9: depth stays within the stack
  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    depthQ <= DW'(DEPTH));

  // R2: a push grows the stack by one
  p_push_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.push |=> (depthQ == $past(depthQ) + DW'(1)));

  // R4: a pop shrinks the stack by one
  p_pop_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.pop |=> (depthQ == $past(depthQ) - DW'(1)));

  // R3: overflow is sticky until a load
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfQ && !strobes.load) |=> ovfQ);

  // R7: a permanent top entry keeps its length and place
  p_forever_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((depthQ != '0) && (topEntry.len == {LEN_W{1'b1}}) && !strobes.load &&
     !strobes.clear && !strobes.push && !strobes.pop)
    |=> ((topEntry.len == {LEN_W{1'b1}}) && (depthQ == $past(depthQ))));

endmodule

// File: rtl/page_stack_ctl.sv
module page_stack_ctl
  import pgstk_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned DW = $clog2(DEPTH + 1),
  localparam int unsigned STATE_W = DEPTH * ENT_W + DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 retire,
  input  logic [1:0]           cmdOp,
  input  logic [PAGE_W-1:0]    cmdPage,
  input  logic [LEN_W-1:0]     cmdLen,
  input  logic                 branchTaken,
  input  logic                 csrWe,
  input  logic [STATE_W-1:0]   csrWdata,
  output logic [STATE_W:0]     csrRdata,
  output logic [PAGE_W-1:0]    subpage,
  output logic                 altActive,
  output logic                 overflow
);

  stackStrobe_t     strobes;
  logic [DW-1:0]    depth;
  pageEntry_t       topEntry;
  logic             ovf;
  logic [STATE_W-1:0] stateImage;

  pgstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .retire      (retire),
    .cmdOp       (cmdOp),
    .branchTaken (branchTaken),
    .csrWe       (csrWe),
    .depth       (depth),
    .topLen      (topEntry.len),
    .strobes     (strobes)
  );

  pgstk_datapath #(.DEPTH(DEPTH)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .pushPage   (cmdPage),
    .pushLen    (cmdLen),
    .loadState  (csrWdata),
    .depth      (depth),
    .topEntry   (topEntry),
    .ovf        (ovf),
    .stateImage (stateImage)
  );

  assign csrRdata  = {ovf, stateImage};
  assign altActive = (depth != '0);
  assign subpage   = topEntry.page;
  assign overflow  = ovf;

  // R8: a branch without a CSR write empties the stack
  p_branch_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (branchTaken && !csrWe) |=> !altActive);

  // R11: no alternate page means subpage zero
  p_idle_page_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !altActive |-> (subpage == '0));

  // R10: a CSR write lands its entries in one cycle
  p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    csrWe |=> (csrRdata[DEPTH*ENT_W-1:0] == $past(csrWdata[DEPTH*ENT_W-1:0])));

endmodule

// File: tb/page_stack_ctl_test.sv
`timescale 1ns/1ps
module page_stack_ctl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        retire;
  logic [1:0]  cmdOp;
  logic [2:0]  cmdPage;
  logic [3:0]  cmdLen;
  logic        branchTaken;
  logic        csrWe;
  logic [30:0] csrWdata;
  logic [31:0] csrRdata;
  logic [2:0]  subpage;
  logic        altActive;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  page_stack_ctl uut (
    .clk(clk), .rst_n(rst_n), .retire(retire), .cmdOp(cmdOp),
    .cmdPage(cmdPage), .cmdLen(cmdLen), .branchTaken(branchTaken),
    .csrWe(csrWe), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .subpage(subpage), .altActive(altActive), .overflow(overflow)
  );

  // {tag, retire, op, page, len, branch, expDepth, expSubpage}
  localparam int NV = 20;
  localparam logic [20:0] VEC [NV] = '{
    {4'd2,  1'b1, 2'd1, 3'd5, 4'd3,  1'b0, 3'd1, 3'd5},
    {4'd6,  1'b1, 2'd0, 3'd0, 4'd0,  1'b0, 3'd1, 3'd5},
    {4'd6,  1'b1, 2'd0, 3'd0, 4'd0,  1'b0, 3'd1, 3'd5},
    {4'd6,  1'b1, 2'd0, 3'd0, 4'd0,  1'b0, 3'd0, 3'd0},
    {4'd2,  1'b1, 2'd1, 3'd2, 4'd15, 1'b0, 3'd1, 3'd2},
    {4'd2,  1'b1, 2'd1, 3'd7, 4'd2,  1'b0, 3'd2, 3'd7},
    {4'd6,  1'b1, 2'd0, 3'd0, 4'd0,  1'b0, 3'd2, 3'd7},
    {4'd6,  1'b1, 2'd0, 3'd0, 4'd0,  1'b0, 3'd1, 3'd2},
    {4'd7,  1'b1, 2'd0, 3'd0, 4'd0,  1'b0, 3'd1, 3'd2},
    {4'd7,  1'b1, 2'd0, 3'd0, 4'd0,  1'b0, 3'd1, 3'd2},
    {4'd11, 1'b0, 2'd1, 3'd3, 4'd4,  1'b0, 3'd1, 3'd2},
    {4'd2,  1'b1, 2'd1, 3'd3, 4'd4,  1'b0, 3'd2, 3'd3},
    {4'd4,  1'b1, 2'd2, 3'd0, 4'd0,  1'b0, 3'd1, 3'd2},
    {4'd4,  1'b1, 2'd2, 3'd0, 4'd0,  1'b0, 3'd0, 3'd0},
    {4'd4,  1'b1, 2'd2, 3'd0, 4'd0,  1'b0, 3'd0, 3'd0},
    {4'd2,  1'b1, 2'd1, 3'd1, 4'd15, 1'b0, 3'd1, 3'd1},
    {4'd2,  1'b1, 2'd1, 3'd4, 4'd15, 1'b0, 3'd2, 3'd4},
    {4'd5,  1'b1, 2'd3, 3'd0, 4'd0,  1'b0, 3'd0, 3'd0},
    {4'd2,  1'b1, 2'd1, 3'd6, 4'd15, 1'b0, 3'd1, 3'd6},
    {4'd8,  1'b1, 2'd1, 3'd3, 4'd5,  1'b1, 3'd0, 3'd0}
  };

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [1:0] op, input logic [2:0] pg,
                      input logic [3:0] ln, input logic br, input logic we,
                      input logic [30:0] wd);
    @(negedge clk);
    retire = r; cmdOp = op; cmdPage = pg; cmdLen = ln;
    branchTaken = br; csrWe = we; csrWdata = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, 2'd0, 3'd0, 4'd0, 1'b0, 1'b0, 31'd0);
  endtask

  function automatic logic [6:0] ent(input logic [2:0] p, input logic [3:0] l);
    return {p, l};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; retire = 0; cmdOp = 0; cmdPage = 0; cmdLen = 0;
    branchTaken = 0; csrWe = 0; csrWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1 csr", csrRdata, 32'd0);
    check("R1 alt", {31'd0, altActive}, 32'd0);
    check("R1 sub", {29'd0, subpage}, 32'd0);
    check("R1 ovf", {31'd0, overflow}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      step(v[16], v[15:14], v[13:11], v[10:7], v[6], 1'b0, 31'd0);
      check({tagName(v[20:17]), " depth"}, {29'd0, csrRdata[30:28]}, {29'd0, v[5:3]});
      check({tagName(v[20:17]), " sub"},   {29'd0, subpage}, {29'd0, v[2:0]});
      check({tagName(v[20:17]), " alt"},   {31'd0, altActive}, {31'd0, (v[5:3] != 3'd0)});
    end

    // Fill the stack, then overflow (R2, R3, R9)
    for (int p = 1; p <= 4; p++) step(1'b1, 2'd1, 3'(p), 4'd15, 1'b0, 1'b0, 31'd0);
    check("R2 full sub", {29'd0, subpage}, 32'd4);
    check("R3 no ovf yet", {31'd0, overflow}, 32'd0);
    step(1'b1, 2'd1, 3'd5, 4'd15, 1'b0, 1'b0, 31'd0);
    check("R9 image", csrRdata,
          {1'b1, 3'd4, ent(3'd4, 4'd15), ent(3'd3, 4'd15), ent(3'd2, 4'd15), ent(3'd1, 4'd15)});
    check("R3 sub kept", {29'd0, subpage}, 32'd4);
    step(1'b1, 2'd2, 3'd0, 4'd0, 1'b0, 1'b0, 31'd0);
    check("R3 sticky", {31'd0, overflow}, 32'd1);
    check("R4 pop depth", {29'd0, csrRdata[30:28]}, 32'd3);

    // CSR write with branch and countdown in the same cycle (R10)
    step(1'b1, 2'd0, 3'd0, 4'd0, 1'b1, 1'b1,
         {3'd2, 7'd0, 7'd0, ent(3'd6, 4'd2), ent(3'd3, 4'd9)});
    check("R10 image", csrRdata, {1'b0, 3'd2, 7'd0, 7'd0, ent(3'd6, 4'd2), ent(3'd3, 4'd9)});
    check("R10 sub", {29'd0, subpage}, 32'd6);
    check("R10 ovf clr", {31'd0, overflow}, 32'd0);
    step(1'b1, 2'd0, 3'd0, 4'd0, 1'b0, 1'b0, 31'd0);
    check("R6 dec", {25'd0, csrRdata[13:7]}, {25'd0, ent(3'd6, 4'd1)});
    step(1'b1, 2'd0, 3'd0, 4'd0, 1'b0, 1'b0, 31'd0);
    check("R6 autopop depth", {29'd0, csrRdata[30:28]}, 32'd1);
    check("R6 autopop sub", {29'd0, subpage}, 32'd3);

    // Depth saturation on restore (R10)
    step(1'b0, 2'd0, 3'd0, 4'd0, 1'b0, 1'b1,
         {3'd7, ent(3'd2, 4'd15), ent(3'd2, 4'd15), ent(3'd2, 4'd15), ent(3'd2, 4'd15)});
    check("R10 sat", {29'd0, csrRdata[30:28]}, 32'd4);
    idle();
    check("R11 idle", {29'd0, csrRdata[30:28]}, 32'd4);

    // Reset mid-run (R1)
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1 rerun csr", csrRdata, 32'd0);
    check("R1 rerun alt", {31'd0, altActive}, 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule